// File: doc/BRIEF.md
# Two-Phase Multiplexed Address Sender

This block sits between a memory controller's request path and a memory device that runs with its address bus folded in half. A request arrives as one wide word: a command, a bank number, a 22-bit address, the data-width setting and the burst-length setting. The block sends it over 11 address lines in two consecutive clock cycles. The command and bank travel with the first half. The second half uses a rearranged bit order, and lanes that the current width and burst do not need are forced low.

Refresh carries only a bank number, so it occupies the bus for a single cycle and the next request can follow on the very next clock. A valid/ready handshake paces the controller. Ready drops for the one cycle in which the second half is still owed. The block also reports the read and write latencies of the selected timing configuration. Both values are one clock longer than without folding, because of the extra address cycle.

Top module: `mux_addr_sender`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_cmd` is NOP (code 0), `bus_bank` and `bus_addr` are zero and `req_ready` is 1.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. For READ (code 1) and WRITE (code 2), the cycle after that edge shows the command, the bank and the first word. In the first word, lane k of `bus_addr` (k = 0..10) carries address bit 0, 3, 4, 5, 8, 9, 10, 13, 14, 17, 18 respectively.
- R3: In the cycle after the first word of a READ or WRITE, the bus shows the second word, with `bus_cmd` NOP and `bus_bank` zero. Lane k carries address bit 20, 1, 2, 21, 6, 7, 19, 11, 12, 16, 15 respectively.
- R4: Don't-care lanes of the second word are driven 0. `req_wide`=1 selects the wide (x18) width and 0 the narrow (x9) width. `req_burst` is 0 for 2 beats, 1 for 4 beats, 2 for 8 beats, and 3 is treated as 8 beats. The rules are:
  - Lane 3 is zero unless the width is narrow and the burst is 2 beats.
  - Lane 0 is zero for 8-beat bursts, and also for wide 4-beat bursts.
  - Lane 6 is zero for wide 8-beat bursts.
- R5: `req_ready` is 0 exactly during the first-word cycle of a READ or WRITE. A request held valid across that cycle is therefore taken one clock later, and the device gets at most one two-phase request every two clocks.
- R6: REFRESH (code 3) is single-phase. The cycle after acceptance shows REFRESH, the bank and an all-zero `bus_addr`, whatever the request address. `req_ready` stays 1, so refreshes can be taken on consecutive clocks.
- R7: In a cycle that follows no accepted request, or an accepted NOP request, and that is not a second-word cycle, the bus shows NOP with zero bank and zero address.
- R8: `cfg_sel` codes 0..4 give `rd_lat` of 5, 7, 9, 4, 6 and `wr_lat` of 6, 8, 10, 5, 7 respectively. Codes 5..7 give 0 on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_cmd | input | 2 | 0 NOP, 1 READ, 2 WRITE, 3 REFRESH |
| req_bank | input | BANK_W (3) | Bank number |
| req_addr | input | 22 | Full request address |
| req_wide | input | 1 | 1 = wide (x18) width, 0 = narrow (x9) width |
| req_burst | input | 2 | 0 = 2 beats, 1 = 4 beats, 2 or 3 = 8 beats |
| cfg_sel | input | 3 | Timing configuration code 0..4 |
| bus_cmd | output | 2 | Command driven to the device |
| bus_bank | output | BANK_W (3) | Bank driven with the first word |
| bus_addr | output | 11 | Folded address lanes |
| rd_lat | output | LAT_W (4) | Read latency in clocks, folded mode |
| wr_lat | output | LAT_W (4) | Write latency in clocks, folded mode |

## Verification
The bench walks every width and burst combination with all-ones and patterned addresses. A lane that is masked under the wrong rule, or a bit that lands in the wrong lane, shows up as a wrong second word. It holds a request valid through the first-word cycle: a design that leaves ready high would overwrite the pending second word or issue two commands back to back. Back-to-back refreshes and refresh with a non-zero address catch a design that spends two cycles on refresh or leaks address bits onto the bus. A reset between the two words catches a stale second word that survives reset.

// File: rtl/mux_addr_pkg.sv
// Shared types and lane maps for the two-phase address sender.
// Assumes a fixed 22-bit request address folded onto 11 lanes.
package mux_addr_pkg;

    localparam int ADDR_W = 22;
    localparam int LANES  = 11;

    // Lanes that may be don't-care in the second word.
    localparam int LANE_HI20 = 0;
    localparam int LANE_HI21 = 3;
    localparam int LANE_HI19 = 6;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_READ    = 2'd1,
        CMD_WRITE   = 2'd2,
        CMD_REFRESH = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BEATS_2   = 2'd0,
        BEATS_4   = 2'd1,
        BEATS_8   = 2'd2,
        BEATS_RSV = 2'd3
    } beats_e;

    // Address bit carried by a lane in the first word.
    function automatic int first_src(input int lane);
        case (lane)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 8;
            5:       return 9;
            6:       return 10;
            7:       return 13;
            8:       return 14;
            9:       return 17;
            default: return 18;
        endcase
    endfunction

    // Address bit carried by a lane in the second word.
    function automatic int second_src(input int lane);
        case (lane)
            0:       return 20;
            1:       return 1;
            2:       return 2;
            3:       return 21;
            4:       return 6;
            5:       return 7;
            6:       return 19;
            7:       return 11;
            8:       return 12;
            9:       return 16;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/mux_addr_lane_map.sv
// Folds the wide address into the two lane words.
// Purely combinational; the second word has its unused lanes cleared.
module mux_addr_lane_map
    import mux_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic [1:0]        burst,
    output logic [LANES-1:0]  first_word,
    output logic [LANES-1:0]  second_word
);

    logic [LANES-1:0] dc_mask;
    logic             is_b8;
    logic             is_b2;

    // Decode the burst setting (reserved code behaves as 8 beats).
    always_comb begin
        is_b8 = (beats_e'(burst) == BEATS_8) || (beats_e'(burst) == BEATS_RSV);
        is_b2 = (beats_e'(burst) == BEATS_2);
    end

    // Mark second-word lanes unused for this width and burst.
    always_comb begin
        dc_mask            = '0;
        dc_mask[LANE_HI21] = !(is_b2 && !wide);
        dc_mask[LANE_HI20] = is_b8 || (wide && !is_b2);
        dc_mask[LANE_HI19] = wide && is_b8;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int SRC_A = first_src(k);
        localparam int SRC_B = second_src(k);
        assign first_word[k]  = addr[SRC_A];
        assign second_word[k] = addr[SRC_B] & ~dc_mask[k];
    end

endmodule

// File: rtl/mux_addr_latency.sv
// Reports read and write latency for the selected timing configuration,
// each one clock above the unfolded value. Unknown codes report zero.
module mux_addr_latency #(
    parameter int LAT_W     = 4,
    parameter int MUX_EXTRA = 1
) (
    input  logic [2:0]       cfg_sel,
    output logic [LAT_W-1:0] rd_lat,
    output logic [LAT_W-1:0] wr_lat
);

    logic [LAT_W-1:0] base_rd;
    logic             known;

    // Unfolded read latency per configuration code.
    always_comb begin
        known = 1'b1;
        case (cfg_sel)
            3'd0:    base_rd = LAT_W'(4);
            3'd1:    base_rd = LAT_W'(6);
            3'd2:    base_rd = LAT_W'(8);
            3'd3:    base_rd = LAT_W'(3);
            3'd4:    base_rd = LAT_W'(5);
            default: begin
                base_rd = '0;
                known   = 1'b0;
            end
        endcase
    end

    // Add the folding penalty; write trails read by one clock.
    always_comb begin
        rd_lat = known ? base_rd + LAT_W'(MUX_EXTRA) : '0;
        wr_lat = known ? base_rd + LAT_W'(MUX_EXTRA + 1) : '0;
    end

endmodule

// File: rtl/mux_addr_seq.sv
// Sequencer: accepts a request, drives the first word with command and
// bank, then the held second word for READ/WRITE. Refresh and NOP take one
// cycle. Outputs are registered; reset is synchronous, active low.
module mux_addr_seq
    import mux_addr_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [LANES-1:0]  first_word,
    input  logic [LANES-1:0]  second_word,
    output logic [1:0]        bus_cmd,
    output logic [BANK_W-1:0] bus_bank,
    output logic [LANES-1:0]  bus_addr
);

    typedef enum logic {ST_FREE, ST_OWED} seq_e;

    seq_e             state;
    logic [LANES-1:0] owed_word;
    logic             take;
    logic             two_phase;

    // Handshake and command class.
    always_comb begin
        req_ready = (state == ST_FREE);
        take      = req_valid && req_ready;
        two_phase = (cmd_e'(req_cmd) == CMD_READ) || (cmd_e'(req_cmd) == CMD_WRITE);
    end

    // Drive the bus one word per clock and track an owed second word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FREE;
            owed_word <= '0;
            bus_cmd   <= CMD_NOP;
            bus_bank  <= '0;
            bus_addr  <= '0;
        end else if (state == ST_OWED) begin
            bus_cmd   <= CMD_NOP;
            bus_bank  <= '0;
            bus_addr  <= owed_word;
            state     <= ST_FREE;
        end else if (take && two_phase) begin
            bus_cmd   <= req_cmd;
            bus_bank  <= req_bank;
            bus_addr  <= first_word;
            owed_word <= second_word;
            state     <= ST_OWED;
        end else if (take && (cmd_e'(req_cmd) == CMD_REFRESH)) begin
            bus_cmd   <= req_cmd;
            bus_bank  <= req_bank;
            bus_addr  <= '0;
        end else begin
            bus_cmd   <= CMD_NOP;
            bus_bank  <= '0;
            bus_addr  <= '0;
        end
    end

endmodule

// File: rtl/mux_addr_sender.sv
// Top: folds a wide memory request onto 11 address lanes in two clocks,
// sends refresh in one, and reports folded-mode latencies.
module mux_addr_sender
    import mux_addr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [21:0]       req_addr,
    input  logic              req_wide,
    input  logic [1:0]        req_burst,
    input  logic [2:0]        cfg_sel,
    output logic [1:0]        bus_cmd,
    output logic [BANK_W-1:0] bus_bank,
    output logic [10:0]       bus_addr,
    output logic [LAT_W-1:0]  rd_lat,
    output logic [LAT_W-1:0]  wr_lat
);

    logic [LANES-1:0] first_word;
    logic [LANES-1:0] second_word;

    mux_addr_lane_map u_map (
        .addr        (req_addr),
        .wide        (req_wide),
        .burst       (req_burst),
        .first_word  (first_word),
        .second_word (second_word)
    );

    mux_addr_seq #(.BANK_W(BANK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cmd     (req_cmd),
        .req_bank    (req_bank),
        .first_word  (first_word),
        .second_word (second_word),
        .bus_cmd     (bus_cmd),
        .bus_bank    (bus_bank),
        .bus_addr    (bus_addr)
    );

    mux_addr_latency #(.LAT_W(LAT_W), .MUX_EXTRA(1)) u_lat (
        .cfg_sel (cfg_sel),
        .rd_lat  (rd_lat),
        .wr_lat  (wr_lat)
    );

endmodule

// File: rtl/mux_addr_sender_chk.sv
// Checker bound to the top: protocol properties of the folded bus.
module mux_addr_sender_chk
    import mux_addr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int LAT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_cmd,
    input logic [BANK_W-1:0] req_bank,
    input logic [1:0]        bus_cmd,
    input logic [BANK_W-1:0] bus_bank,
    input logic [10:0]       bus_addr,
    input logic [LAT_W-1:0]  rd_lat,
    input logic [LAT_W-1:0]  wr_lat
);

    // R5: a taken READ/WRITE blocks the next cycle
    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_cmd == CMD_READ || req_cmd == CMD_WRITE)) |=> !req_ready);

    // R5: the block is never busy two cycles in a row
    a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R3: the second word carries no command and no bank
    a_r3_second_word_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (bus_cmd == CMD_NOP && bus_bank == '0));

    // R2: command and bank follow the accepted request
    a_r2_cmd_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cmd != CMD_NOP) |=>
        (bus_cmd == $past(req_cmd) && bus_bank == $past(req_bank)));

    // R6: refresh is one cycle with zero lanes and no stall
    a_r6_refresh_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cmd == CMD_REFRESH) |=>
        (req_ready && bus_addr == '0));

    // R7: nothing taken means an idle bus
    a_r7_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> (bus_cmd == CMD_NOP && bus_bank == '0 && bus_addr == '0));

    // R8: write latency trails read latency by one clock
    a_r8_lat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lat != '0) |-> (wr_lat == rd_lat + LAT_W'(1)));

endmodule

bind mux_addr_sender mux_addr_sender_chk #(.BANK_W(BANK_W), .LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .bus_cmd   (bus_cmd),
    .bus_bank  (bus_bank),
    .bus_addr  (bus_addr),
    .rd_lat    (rd_lat),
    .wr_lat    (wr_lat)
);

// File: tb/mux_addr_sender_tb_top.sv
`timescale 1ns/1ps
module mux_addr_sender_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cmd = 2'd0;
    logic [2:0]  req_bank = 3'd0;
    logic [21:0] req_addr = '0;
    logic        req_wide = 1'b0;
    logic [1:0]  req_burst = 2'd0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [1:0]  bus_cmd;
    logic [2:0]  bus_bank;
    logic [10:0] bus_addr;
    logic [3:0]  rd_lat;
    logic [3:0]  wr_lat;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mux_addr_sender dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_bank(req_bank), .req_addr(req_addr),
        .req_wide(req_wide), .req_burst(req_burst), .cfg_sel(cfg_sel),
        .bus_cmd(bus_cmd), .bus_bank(bus_bank), .bus_addr(bus_addr),
        .rd_lat(rd_lat), .wr_lat(wr_lat)
    );

    // Vector: cmd[29:28] bank[27:25] addr[24:3] wide[2] burst[1:0]
    localparam logic [29:0] VECS [10] = '{
        {2'd1, 3'd0, 22'h3FFFFF, 1'b0, 2'd0},
        {2'd2, 3'd7, 22'h3FFFFF, 1'b1, 2'd0},
        {2'd1, 3'd3, 22'h3FFFFF, 1'b1, 2'd1},
        {2'd2, 3'd5, 22'h3FFFFF, 1'b0, 2'd1},
        {2'd1, 3'd1, 22'h3FFFFF, 1'b1, 2'd2},
        {2'd2, 3'd6, 22'h3FFFFF, 1'b0, 2'd2},
        {2'd1, 3'd2, 22'h2AAAAA, 1'b0, 2'd0},
        {2'd2, 3'd4, 22'h155555, 1'b0, 2'd3},
        {2'd3, 3'd6, 22'h3FFFFF, 1'b0, 2'd0},
        {2'd1, 3'd0, 22'h000001, 1'b1, 2'd0}
    };

    function automatic logic [10:0] exp_first(input logic [21:0] a);
        return {a[18], a[17], a[14], a[13], a[10], a[9], a[8], a[5], a[4], a[3], a[0]};
    endfunction

    function automatic logic [10:0] exp_second(input logic [21:0] a, input logic w, input logic [1:0] b);
        logic [10:0] v;
        v = {a[15], a[16], a[12], a[11], a[19], a[7], a[6], a[21], a[2], a[1], a[20]};
        if (!(w == 1'b0 && b == 2'd0)) v[3] = 1'b0;
        if (b >= 2'd2 || (w && b == 2'd1)) v[0] = 1'b0;
        if (w && b >= 2'd2) v[6] = 1'b0;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(bus_cmd == 2'd0 && bus_bank == 3'd0 && bus_addr == '0 && req_ready,
            req, {16'd0, req_ready, bus_cmd, bus_bank, bus_addr}, {16'd0, 1'b1, 15'd0});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        // R2 R3 R4 R6: walk the vector table
        foreach (VECS[i]) begin
            logic [1:0]  c;
            logic [2:0]  bk;
            logic [21:0] ad;
            logic        w;
            logic [1:0]  bu;
            {c, bk, ad, w, bu} = VECS[i];
            req_valid = 1'b1; req_cmd = c; req_bank = bk; req_addr = ad;
            req_wide = w; req_burst = bu;
            @(negedge clk);
            req_valid = 1'b0;
            chk(bus_cmd == c && bus_bank == bk, "R2 cmd/bank", {bus_cmd, bus_bank}, {c, bk});
            if (c == 2'd3) begin
                chk(bus_addr == '0 && req_ready, "R6 refresh lanes/ready",
                    {req_ready, bus_addr}, {1'b1, 11'd0});
            end else begin
                chk(bus_addr == exp_first(ad), "R2 first word", bus_addr, exp_first(ad));
                chk(!req_ready, "R5 ready low in first word", req_ready, 0);
                @(negedge clk);
                chk(bus_cmd == 2'd0 && bus_bank == 3'd0, "R3 second word cmd/bank",
                    {bus_cmd, bus_bank}, 0);
                chk(bus_addr == exp_second(ad, w, bu), "R4 second word lanes",
                    bus_addr, exp_second(ad, w, bu));
            end
            @(negedge clk);
            chk_idle("R7 idle after request");
        end

        // R5: request held valid through the stall cycle
        req_valid = 1'b1; req_cmd = 2'd1; req_bank = 3'd3; req_addr = 22'h0F0F0F;
        req_wide = 1'b0; req_burst = 2'd0;
        @(negedge clk);
        chk(!req_ready && bus_cmd == 2'd1, "R5 first taken", {req_ready, bus_cmd}, 2'd1);
        req_cmd = 2'd2; req_bank = 3'd5; req_addr = 22'h30C30C;
        @(negedge clk);
        chk(bus_cmd == 2'd0 && bus_addr == exp_second(22'h0F0F0F, 1'b0, 2'd0),
            "R5 held request not taken early", {bus_cmd, bus_addr},
            {2'd0, exp_second(22'h0F0F0F, 1'b0, 2'd0)});
        chk(req_ready, "R5 ready back", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cmd == 2'd2 && bus_bank == 3'd5 && bus_addr == exp_first(22'h30C30C),
            "R5 second request first word", {bus_cmd, bus_bank, bus_addr},
            {2'd2, 3'd5, exp_first(22'h30C30C)});
        @(negedge clk);
        @(negedge clk);
        chk_idle("R7 idle after pair");

        // R6: back-to-back refresh
        req_valid = 1'b1; req_cmd = 2'd3; req_bank = 3'd2; req_addr = 22'h3FFFFF;
        @(negedge clk);
        chk(bus_cmd == 2'd3 && bus_bank == 3'd2 && req_ready, "R6 refresh 1",
            {req_ready, bus_cmd, bus_bank}, {1'b1, 2'd3, 3'd2});
        req_bank = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cmd == 2'd3 && bus_bank == 3'd5 && bus_addr == '0, "R6 refresh 2 next clock",
            {bus_cmd, bus_bank, bus_addr}, {2'd3, 3'd5, 11'd0});
        @(negedge clk);
        chk_idle("R7 idle after refresh");

        // R7: NOP request with junk fields
        req_valid = 1'b1; req_cmd = 2'd0; req_bank = 3'd7; req_addr = 22'h3FFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk_idle("R7 NOP request");

        // R1: reset between the two words drops the owed word
        req_valid = 1'b1; req_cmd = 2'd2; req_bank = 3'd1; req_addr = 22'h3FFFFF;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset mid-request");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 no stale second word");

        // R8: latency per configuration code
        for (int c = 0; c < 8; c++) begin
            logic [3:0] er;
            logic [3:0] ew;
            cfg_sel = 3'(c);
            case (c)
                0: begin er = 4'd5; ew = 4'd6;  end
                1: begin er = 4'd7; ew = 4'd8;  end
                2: begin er = 4'd9; ew = 4'd10; end
                3: begin er = 4'd4; ew = 4'd5;  end
                4: begin er = 4'd6; ew = 4'd7;  end
                default: begin er = 4'd0; ew = 4'd0; end
            endcase
            @(negedge clk);
            chk(rd_lat == er && wr_lat == ew, "R8 latency", {rd_lat, wr_lat}, {er, ew});
        end

        finish_run();
    end

endmodule